// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Loader

This block takes a configuration image as a stream of bytes and loads it into a target FPGA through that device's byte-wide slave configuration port. The stream uses a valid/ready handshake and carries a flag that marks the final byte. Everything that comes before the synchronisation run of 0xFF bytes is thrown away. The sync run is forwarded to the target, and every byte after it is forwarded too. The stream stays stalled while each byte is clocked out.

Software or a DMA engine pulses `start` and then streams the image in. The block first drives the program line and waits for the target to raise its init line. It then enables writes and selects the device. Each byte is bit-reversed and clocked in with a slow low/high/low pulse. After the last byte it deselects the device, releases the write line, and reports pass or fail from the target's done line. A byte counter stays visible for reporting.

Top module: `cfg_loader`

## Requirements
- R1: After reset, and whenever no session is running, the outputs are idle: `prog_o`=0, `write_o`=0, `cs_n_o`=1, `cclk_o`=0, `in_ready`=0 and `busy`=0. While no session has run, all status flags and `byte_count` are 0.
- R2: A sync run is SYNC_LEN (4) consecutive accepted bytes equal to 0xFF. Any other byte resets the run to zero. Bytes accepted before the run completes are never sent to the target and are not counted.
- R3: If the run has not completed within the first WINDOW (256) accepted bytes, or the stream ends first, the session ends with `sync_err`=1. In that case `prog_o` is never asserted and the device is never selected. The WINDOW-th byte may still complete the run.
- R4: Once sync is found, the SYNC_LEN 0xFF bytes are sent to the target first, and only then the bytes that follow them. This holds even when the last sync byte carries the end flag.
- R5: The start sequence is fixed. `prog_o`=1 with `cs_n_o`=1 and `write_o`=0 is held until `init_in` is high. Then `write_o` rises while `cs_n_o` is still 1. Only in a later cycle does `cs_n_o` fall (chip-select is active low).
- R6: Each byte is driven bit-reversed: input bit i appears on `data_o` bit 7-i.
- R7: Each byte is clocked in three phases: `cclk_o` low, then high, then low. Each phase lasts PHASE_CYC (2) cycles. `data_o` stays stable throughout, and `in_ready` is 0 while a byte is being clocked.
- R8: At the end, `cs_n_o` returns to 1 with `cclk_o`=0 while `write_o` is still 1. `write_o` falls in a later cycle.
- R9: `done_in` is sampled in the cycle after write is released. A value of 1 sets `cfg_ok`; a value of 0 sets `cfg_fail`.
- R10: `byte_count` equals the number of bytes sent to the target, counting from the first sync byte.
- R11: If `init_in` stays low for INIT_TMO (1000) cycles, the session ends with `init_err`=1, and the device is never selected.
- R12: A `start` pulse while `busy`=1 has no effect. A `start` pulse while idle clears the sync state, `byte_count` and all status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a session (honoured only while idle) |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | DW | Stream byte |
| in_last | input | 1 | Marks the final byte of the image |
| in_ready | output | 1 | Block accepts a byte this cycle |
| init_in | input | 1 | Target init status, high = ready to take data |
| done_in | input | 1 | Target done status |
| prog_o | output | 1 | Program line, high for the whole session from sync onwards |
| write_o | output | 1 | Write-enable line, active high |
| cs_n_o | output | 1 | Chip-select, active low |
| cclk_o | output | 1 | Configuration clock |
| data_o | output | DW | Bit-reversed configuration byte |
| byte_count | output | CNT_W | Bytes sent to the target |
| busy | output | 1 | A session is active |
| cfg_ok | output | 1 | Done was high after release |
| cfg_fail | output | 1 | Done was low after release |
| sync_err | output | 1 | No sync run found in time |
| init_err | output | 1 | Init never went high |

## Verification
The bench sends a broken run (three 0xFF bytes, then a zero) and checks that it is rejected. A design that does not reset its run counter would sync there and start programming. It also places the sync run so that it ends exactly on byte 256, and sends 256 bytes with no sync. A window that is off by one either rejects a valid image or keeps scanning past the limit. The bench ends the stream on the last sync byte, where a design that drops the replayed sync bytes sends nothing and counts zero. A monitor watches the select and release order and the clock phase lengths, so write and select changing in the same cycle is reported, as is a wrong bit order on the data lines. Finally, `start` is pulsed in the middle of a scan: if it restarts the session, the sync run is lost and the image never loads.

// File: rtl/cfgl_pkg.sv
// Shared types for the configuration loader.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package cfgl_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_SCAN,
        S_PROG,
        S_WREN,
        S_SEL,
        S_REPLAY,
        S_STREAM,
        S_DESEL,
        S_WRREL
    } cfgl_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LO1,
        PH_HI,
        PH_LO2
    } strobe_ph_e;
endpackage

// File: rtl/cfgl_sync_scan.sv
// Sync-run scanner. Counts consecutive all-ones bytes and the number of bytes
// seen since the last clear. Flags the byte that completes the run, and the
// byte that fills the search window without a run.
// Assumes: take is only high for accepted bytes during the scan phase.
module cfgl_sync_scan #(
    parameter int DW       = 8,
    parameter int SYNC_LEN = 4,
    parameter int WINDOW   = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          take,
    input  logic [DW-1:0] byte_in,
    output logic          found,
    output logic          window_out
);
    localparam int RW = $clog2(SYNC_LEN + 1);
    localparam int SW = $clog2(WINDOW + 1);

    logic [RW-1:0] run;
    logic [SW-1:0] seen;
    logic          is_pat;

    // Pattern match and completion/overflow decode for the current byte.
    always_comb begin
        is_pat     = (byte_in == {DW{1'b1}});
        found      = take && is_pat && (run == RW'(SYNC_LEN - 1));
        window_out = take && !found && (seen == SW'(WINDOW - 1));
    end

    // Run length and window position, cleared on session start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run  <= '0;
            seen <= '0;
        end else if (take) begin
            if (is_pat && !found) run <= run + 1'b1;
            else                  run <= '0;
            if (seen != SW'(WINDOW)) seen <= seen + 1'b1;
        end
    end

    a_r2_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run < RW'(SYNC_LEN));
    a_r3_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        seen <= SW'(WINDOW));
endmodule

// File: rtl/cfgl_strobe.sv
// Byte strobe engine. On go it latches the byte bit-reversed, then runs the
// clock through low, high and low phases of PHASE_CYC cycles each. The data
// is held until the next byte is started.
// Assumes: go is only raised while busy is low.
module cfgl_strobe
    import cfgl_pkg::*;
#(
    parameter int DW        = 8,
    parameter int PHASE_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          go,
    input  logic [DW-1:0] din,
    output logic          busy,
    output logic          cclk,
    output logic [DW-1:0] dout
);
    localparam int PCW = $clog2(PHASE_CYC + 1);

    strobe_ph_e    ph;
    logic [PCW-1:0] cnt;
    logic [DW-1:0]  rev;

    // Mirror the bit order of the incoming byte.
    for (genvar i = 0; i < DW; i++) begin : g_rev
        assign rev[i] = din[DW-1-i];
    end

    // Phase and per-phase cycle counter; latch the byte on go.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ph   <= PH_IDLE;
            cnt  <= '0;
            dout <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (go) begin
                        ph   <= PH_LO1;
                        cnt  <= '0;
                        dout <= rev;
                    end
                end
                default: begin
                    if (cnt == PCW'(PHASE_CYC - 1)) begin
                        cnt <= '0;
                        case (ph)
                            PH_LO1:  ph <= PH_HI;
                            PH_HI:   ph <= PH_LO2;
                            default: ph <= PH_IDLE;
                        endcase
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Status and clock decode from the phase.
    always_comb begin
        busy = (ph != PH_IDLE);
        cclk = (ph == PH_HI);
    end

    a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dout));
    a_r7_go_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);
endmodule

// File: rtl/cfg_loader.sv
// Configuration loader top. Scans the input stream for the sync run, then
// drives the program/write/select sequence, replays the sync bytes, clocks
// each following byte through the strobe engine, releases the port and
// samples done.
// Assumes: init_in and done_in are already synchronous to clk.
module cfg_loader
    import cfgl_pkg::*;
#(
    parameter int DW        = 8,
    parameter int PHASE_CYC = 2,
    parameter int SYNC_LEN  = 4,
    parameter int WINDOW    = 256,
    parameter int INIT_TMO  = 1000,
    parameter int CNT_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    input  logic             in_last,
    output logic             in_ready,
    input  logic             init_in,
    input  logic             done_in,
    output logic             prog_o,
    output logic             write_o,
    output logic             cs_n_o,
    output logic             cclk_o,
    output logic [DW-1:0]    data_o,
    output logic [CNT_W-1:0] byte_count,
    output logic             busy,
    output logic             cfg_ok,
    output logic             cfg_fail,
    output logic             sync_err,
    output logic             init_err
);
    localparam int RPW = $clog2(SYNC_LEN + 1);
    localparam int TW  = $clog2(INIT_TMO + 2);

    cfgl_state_e    state, nxt;
    logic [RPW-1:0] rep_left;
    logic           last_seen;
    logic [TW-1:0]  tmo_cnt;
    logic           session_clr;
    logic           take, found, window_out;
    logic           accept, sb_go, sb_busy;
    logic [DW-1:0]  sb_din;
    logic           tmo_hit;

    cfgl_sync_scan #(.DW(DW), .SYNC_LEN(SYNC_LEN), .WINDOW(WINDOW)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (session_clr),
        .take       (take),
        .byte_in    (in_data),
        .found      (found),
        .window_out (window_out)
    );

    cfgl_strobe #(.DW(DW), .PHASE_CYC(PHASE_CYC)) u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (session_clr),
        .go    (sb_go),
        .din   (sb_din),
        .busy  (sb_busy),
        .cclk  (cclk_o),
        .dout  (data_o)
    );

    // Handshake, strobe launch and timeout decode.
    always_comb begin
        session_clr = (state == S_IDLE) && start;
        in_ready    = (state == S_SCAN) ||
                      ((state == S_STREAM) && !sb_busy && !last_seen);
        accept      = in_valid && in_ready;
        take        = accept && (state == S_SCAN);
        sb_go       = ((state == S_REPLAY) && !sb_busy && (rep_left != '0)) ||
                      ((state == S_STREAM) && accept);
        sb_din      = (state == S_REPLAY) ? {DW{1'b1}} : in_data;
        tmo_hit     = (INIT_TMO != 0) && !init_in &&
                      (tmo_cnt == TW'(INIT_TMO - 1));
    end

    // Next-state selection for the session sequence.
    always_comb begin
        nxt = state;
        case (state)
            S_IDLE:   if (start) nxt = S_SCAN;
            S_SCAN: begin
                if (take) begin
                    if (found)                        nxt = S_PROG;
                    else if (window_out || in_last)   nxt = S_IDLE;
                end
            end
            S_PROG: begin
                if (init_in)      nxt = S_WREN;
                else if (tmo_hit) nxt = S_IDLE;
            end
            S_WREN:   nxt = S_SEL;
            S_SEL:    nxt = S_REPLAY;
            S_REPLAY: if (rep_left == '0 && !sb_busy)
                          nxt = last_seen ? S_DESEL : S_STREAM;
            S_STREAM: if (!sb_busy && last_seen) nxt = S_DESEL;
            S_DESEL:  nxt = S_WRREL;
            S_WRREL:  nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Session bookkeeping: replay count, end flag, init timer, byte count.
    always_ff @(posedge clk) begin
        if (!rst_n || session_clr) begin
            rep_left   <= RPW'(SYNC_LEN);
            last_seen  <= 1'b0;
            tmo_cnt    <= '0;
            byte_count <= '0;
        end else begin
            if (take && found && in_last)           last_seen <= 1'b1;
            if ((state == S_STREAM) && accept && in_last) last_seen <= 1'b1;
            if ((state == S_REPLAY) && sb_go)       rep_left <= rep_left - 1'b1;
            if (state == S_PROG)                    tmo_cnt <= tmo_cnt + 1'b1;
            if (sb_go)                              byte_count <= byte_count + 1'b1;
        end
    end

    // Result flags, cleared on session start.
    always_ff @(posedge clk) begin
        if (!rst_n || session_clr) begin
            cfg_ok   <= 1'b0;
            cfg_fail <= 1'b0;
            sync_err <= 1'b0;
            init_err <= 1'b0;
        end else begin
            if (take && !found && (window_out || in_last)) sync_err <= 1'b1;
            if ((state == S_PROG) && !init_in && tmo_hit)  init_err <= 1'b1;
            if (state == S_WRREL) begin
                cfg_ok   <= done_in;
                cfg_fail <= !done_in;
            end
        end
    end

    // Port line decode from the session state.
    always_comb begin
        busy    = (state != S_IDLE);
        prog_o  = (state == S_PROG)   || (state == S_WREN)   || (state == S_SEL) ||
                  (state == S_REPLAY) || (state == S_STREAM) ||
                  (state == S_DESEL)  || (state == S_WRREL);
        write_o = (state == S_WREN)   || (state == S_SEL)    ||
                  (state == S_REPLAY) || (state == S_STREAM) || (state == S_DESEL);
        cs_n_o  = !((state == S_SEL) || (state == S_REPLAY) || (state == S_STREAM));
    end

    a_r5_select_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> write_o);
    a_r5_write_needs_prog: assert property (@(posedge clk) disable iff (!rst_n)
        write_o |-> prog_o);
    a_r5_select_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> $past(write_o));
    a_r8_release_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(write_o) |-> ($past(cs_n_o) && cs_n_o));
    a_r7_cclk_selected: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_o |-> !cs_n_o);
    a_r7_stall_while_clocking: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_o |-> !in_ready);
    a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_ok && cfg_fail));
    a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_count != $past(byte_count)) |->
        ((byte_count == $past(byte_count) + CNT_W'(1)) || (byte_count == '0)));
    a_r11_timeout_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        init_err |-> cs_n_o);
    a_r3_syncerr_no_prog: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> !prog_o);
endmodule

// File: tb/tb_cfg_loader.sv
// Directed bench for the configuration loader: one task per scenario.
module tb_cfg_loader;
    localparam int CLK_P = 10;
    localparam int PH    = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        init_in = 1'b0;
    logic        done_in = 1'b0;
    logic        prog_o, write_o, cs_n_o, cclk_o;
    logic [7:0]  data_o;
    logic [31:0] byte_count;
    logic        busy, cfg_ok, cfg_fail, sync_err, init_err;

    int total = 0;
    int bad   = 0;

    // monitor state
    logic [7:0] cap [0:255];
    int ncap = 0;
    int order_bad = 0, hi_bad = 0, lo_bad = 0, ready_bad = 0;
    int prog_cyc = 0, cs_low_cyc = 0;
    int hi_run = 0, lo_run = 0;
    bit had_fall = 0;
    logic prev_w = 0, prev_cs = 1, prev_c = 0;

    always #(CLK_P/2) clk = ~clk;

    cfg_loader dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .init_in(init_in), .done_in(done_in),
        .prog_o(prog_o), .write_o(write_o), .cs_n_o(cs_n_o), .cclk_o(cclk_o),
        .data_o(data_o), .byte_count(byte_count), .busy(busy),
        .cfg_ok(cfg_ok), .cfg_fail(cfg_fail), .sync_err(sync_err), .init_err(init_err)
    );

    // Port monitor: captures bytes on clock rises, checks ordering and phases.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prog_o) prog_cyc++;
            if (!cs_n_o) cs_low_cyc++;
            if (in_ready && cclk_o) ready_bad++;
            if (prev_cs && !cs_n_o && !prev_w) order_bad++;        // R5
            if (!prev_cs && cs_n_o && cclk_o) order_bad++;         // R8
            if (prev_w && !write_o && !prev_cs) order_bad++;       // R8
            if (cclk_o && !prev_c) begin
                if (ncap < 256) cap[ncap] = data_o;
                ncap++;
                if (had_fall && lo_run < 2*PH) lo_bad++;           // R7
                hi_run = 0;
            end
            if (cclk_o) hi_run++;
            else lo_run++;
            if (!cclk_o && prev_c) begin
                if (hi_run != PH) hi_bad++;                        // R7
                had_fall = 1;
                lo_run = 1;
            end
            if (cs_n_o) had_fall = 0;
            prev_w = write_o; prev_cs = cs_n_o; prev_c = cclk_o;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic l);
        bit acc = 0;
        in_valid = 1'b1; in_data = b; in_last = l;
        while (!acc) begin
            acc = in_ready;
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 prog", prog_o, 0);
        chk("R1 write", write_o, 0);
        chk("R1 cs_n", cs_n_o, 1);
        chk("R1 cclk", cclk_o, 0);
        chk("R1 ready", in_ready, 0);
        chk("R1 busy", busy, 0);
        chk("R1 flags", {cfg_ok, cfg_fail, sync_err, init_err}, 0);
        chk("R1 count", byte_count, 0);
    endtask

    task automatic t_normal();
        int base = ncap;
        int ob = order_bad;
        init_in = 0; done_in = 1;
        do_start();
        send_byte(8'h12, 0); send_byte(8'hFF, 0); send_byte(8'hFF, 0); send_byte(8'h00, 0);
        for (int i = 0; i < 4; i++) send_byte(8'hFF, 0);
        repeat (5) @(negedge clk);
        chk("R5 prog while init low", prog_o, 1);
        chk("R5 write low while init low", write_o, 0);
        chk("R5 cs_n high while init low", cs_n_o, 1);
        chk("R2 nothing sent before sync", ncap - base, 0);
        init_in = 1;
        send_byte(8'h01, 0); send_byte(8'h80, 0); send_byte(8'h03, 1);
        wait_idle();
        chk("R4 bytes sent", ncap - base, 7);
        for (int i = 0; i < 4; i++) chk("R4 replayed sync byte", cap[base+i], 8'hFF);
        chk("R6 reverse 01", cap[base+4], 8'h80);
        chk("R6 reverse 80", cap[base+5], 8'h01);
        chk("R6 reverse 03", cap[base+6], 8'hC0);
        chk("R10 count", byte_count, 7);
        chk("R9 ok", cfg_ok, 1);
        chk("R9 no fail", cfg_fail, 0);
        chk("R5 R8 ordering", order_bad - ob, 0);
        chk("R7 high phase length", hi_bad, 0);
        chk("R7 low phase length", lo_bad, 0);
        chk("R7 no ready while clocking", ready_bad, 0);
        chk("R1 prog released", prog_o, 0);
        init_in = 0;
    endtask

    task automatic t_last_on_sync();
        int base = ncap;
        init_in = 1; done_in = 0;
        do_start();
        for (int i = 0; i < 3; i++) send_byte(8'hFF, 0);
        send_byte(8'hFF, 1);
        wait_idle();
        chk("R4 only sync bytes sent", ncap - base, 4);
        chk("R10 count sync only", byte_count, 4);
        chk("R9 fail on done low", cfg_fail, 1);
        chk("R9 no ok on done low", cfg_ok, 0);
        init_in = 0;
    endtask

    task automatic t_busy_restart();
        int base = ncap;
        init_in = 1; done_in = 1;
        do_start();
        chk("R12 flags cleared", {cfg_ok, cfg_fail, sync_err, init_err}, 0);
        chk("R12 count cleared", byte_count, 0);
        chk("R12 busy", busy, 1);
        send_byte(8'hFF, 0); send_byte(8'hFF, 0);
        do_start();
        send_byte(8'hFF, 0); send_byte(8'hFF, 0);
        send_byte(8'hF0, 1);
        wait_idle();
        chk("R12 start ignored, count", byte_count, 5);
        chk("R12 start ignored, ok", cfg_ok, 1);
        chk("R6 reverse F0", cap[base+4], 8'h0F);
        init_in = 0;
    endtask

    task automatic t_broken_run();
        int base = ncap;
        int pc = prog_cyc;
        do_start();
        for (int i = 0; i < 3; i++) send_byte(8'hFF, 0);
        send_byte(8'h00, 0);
        for (int i = 0; i < 3; i++) send_byte(8'hFF, 0);
        send_byte(8'h5A, 1);
        @(negedge clk);
        chk("R2 broken run no sync", sync_err, 1);
        chk("R3 prog never asserted", prog_cyc - pc, 0);
        chk("R2 nothing sent", ncap - base, 0);
        chk("R2 count zero", byte_count, 0);
    endtask

    task automatic t_window_miss();
        int pc = prog_cyc;
        do_start();
        for (int i = 0; i < 255; i++) send_byte(8'h00, 0);
        chk("R3 still scanning at 255", busy, 1);
        chk("R3 no error at 255", sync_err, 0);
        send_byte(8'h00, 0);
        chk("R3 error at 256", sync_err, 1);
        chk("R3 idle after window", busy, 0);
        chk("R3 prog never asserted", prog_cyc - pc, 0);
    endtask

    task automatic t_window_edge();
        int base = ncap;
        init_in = 1; done_in = 1;
        do_start();
        for (int i = 0; i < 252; i++) send_byte(8'h00, 0);
        for (int i = 0; i < 4; i++) send_byte(8'hFF, 0);
        chk("R3 sync on byte 256 accepted", sync_err, 0);
        send_byte(8'h03, 1);
        wait_idle();
        chk("R3 edge bytes sent", ncap - base, 5);
        chk("R10 edge count", byte_count, 5);
        chk("R9 edge ok", cfg_ok, 1);
        init_in = 0;
    endtask

    task automatic t_init_timeout();
        int cl = cs_low_cyc;
        init_in = 0;
        do_start();
        for (int i = 0; i < 4; i++) send_byte(8'hFF, 0);
        wait_idle();
        chk("R11 init error", init_err, 1);
        chk("R11 never selected", cs_low_cyc - cl, 0);
        chk("R11 prog released", prog_o, 0);
        chk("R11 nothing sent", byte_count, 0);
        chk("R11 no verdict", {cfg_ok, cfg_fail}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_last_on_sync();
        t_busy_restart();
        t_broken_run();
        t_window_miss();
        t_window_edge();
        t_init_timeout();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule